// File: doc/BRIEF.md
# Torus Router Route-Lookup Stage

This block is the routing stage at one input port of a seven-port 3-D torus router. Port 0 is the processor injection and ejection port. Ports 1 to 6 are the +X, -X, +Y, -Y, +Z and -Z links. Flits arrive on a valid/ready stream. The header flit of each packet carries a destination node number, a virtual channel bit and an age field.

The stage first splits the destination into a 3-bit region number and a 12-bit node offset. If the region is this node's own region, the stage reads a 4096-entry node table indexed by the offset. Otherwise it reads an 8-entry region table that points toward the destination region. Each table entry gives an output port and a virtual channel. The virtual channel is then rewritten by a dateline rule:
- A packet leaving through a link marked as a dateline crossing is moved to VC1.
- A packet continuing in the dimension it arrived on keeps its incoming VC.
- A packet turning into a new dimension, or heading to the processor, takes the VC from the table.

The decision is registered, so one flit can be accepted every clock. Body and tail flits follow the route latched from their header. A register-style write port loads one table entry per clock.

The output follows the valid/ready rules:
- A flit moves when valid and ready are both high.
- While `out_valid` is high and `out_ready` is low, every output holds.
- `in_ready` is high whenever the output register is empty or is being drained in that cycle.

Top module: `torus_route_stage`

## Requirements
- R1: While reset is held and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When header destination bits [14:12] equal `cfg_my_region`, the route comes from the node table entry at destination bits [11:0].
- R3: When header destination bits [14:12] differ from `cfg_my_region`, the route comes from the region table entry at destination bits [14:12]. The node table is not consulted.
- R4: If the chosen output port p (0..6) has `cfg_dateline[p]` set, the outgoing VC is 1.
- R5: If R4 does not apply and the output port lies in the same dimension as `cfg_in_port`, the incoming header VC is kept. Ports 1 and 2 form dimension X, ports 3 and 4 form Y, ports 5 and 6 form Z, and port 0 has no dimension.
- R6: Otherwise (new dimension, or processor port 0) the outgoing VC is the table VC.
- R7: A flit accepted in cycle t is presented on the outputs in cycle t+1. Back-to-back flits are accepted every cycle while `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and all outputs hold their values.
- R9: A header looked up in the same cycle as a table write to the same entry gets the entry's old value. The new value is used from the next cycle.
- R10: Flit layout is destination [14:0], VC bit [15] and age [23:16]:
  - For a header, `out_data` equals `in_data` with bit 15 replaced by `out_vc`.
  - Body and tail flits pass `in_data` unchanged and carry the port and VC of their packet's header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_my_region | input | 3 | Region number of this node |
| cfg_in_port | input | 3 | Which router port this stage serves (0..6) |
| cfg_dateline | input | 7 | Bit p set: output port p crosses a dateline |
| tbl_we | input | 1 | Table write strobe |
| tbl_global | input | 1 | 1 selects the region table, 0 the node table |
| tbl_addr | input | 12 | Entry index (low 3 bits for the region table) |
| tbl_port | input | 3 | Output port to store |
| tbl_vc | input | 1 | Virtual channel to store |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Stage can take a flit |
| in_head | input | 1 | Flit is a packet header |
| in_tail | input | 1 | Flit is the last of its packet |
| in_data | input | 24 | Flit contents |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream takes the flit |
| out_head | output | 1 | Output flit is a header |
| out_tail | output | 1 | Output flit is a tail |
| out_data | output | 24 | Flit contents, header VC rewritten |
| out_port | output | 3 | Chosen output port |
| out_vc | output | 1 | Chosen virtual channel |

## Verification
The checks assume the configuration pins stay constant while flits are in flight. They also assume that every stored table entry names a port from 0 to 6, and that each packet begins with a header. The stimulus programs the configuration once after reset and loads only legal port numbers into both tables. Every test packet starts with a flagged header. Input changes happen only at the falling clock edge, and a stalled flit is held on the inputs until it is accepted.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
  localparam int NPORTS = 7;
  localparam int PORT_W = 3;
  localparam logic [1:0] DIM_NONE = 2'd3;

  typedef logic [PORT_W-1:0] port_t;

  typedef struct packed {
    port_t port;
    logic  vc;
  } route_t;

  // Ports 1/2 -> X (0), 3/4 -> Y (1), 5/6 -> Z (2), processor -> none
  function automatic logic [1:0] port_dim(port_t p);
    port_t q;
    if (p == '0 || int'(p) >= NPORTS) return DIM_NONE;
    q = p - port_t'(1);
    return q[2:1];
  endfunction
endpackage

// File: rtl/route_table.sv
module route_table
  import torus_route_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  route_t        wdata,
  input  logic [AW-1:0] raddr,
  output route_t        rdata
);
  localparam int DEPTH = 1 << AW;

  route_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read sees the value before any write in the same cycle
  assign rdata = mem[raddr];
endmodule

// File: rtl/route_decide.sv
module route_decide
  import torus_route_pkg::*;
#(
  parameter int LOCAL_AW  = 12,
  parameter int GLOBAL_AW = 3
) (
  input  logic [LOCAL_AW+GLOBAL_AW-1:0] dest,
  input  logic                          in_vc,
  input  logic [GLOBAL_AW-1:0]          my_region,
  input  port_t                         in_port,
  input  logic [NPORTS-1:0]             dateline,
  output logic [LOCAL_AW-1:0]           local_addr,
  output logic [GLOBAL_AW-1:0]          global_addr,
  input  route_t                        local_route,
  input  route_t                        global_route,
  output route_t                        decided
);
  localparam int NODE_W = LOCAL_AW + GLOBAL_AW;

  logic       use_local;
  logic       crosses;
  logic [1:0] in_dim;
  logic [1:0] out_dim;
  route_t     base;

  assign global_addr = dest[NODE_W-1 -: GLOBAL_AW];
  assign local_addr  = dest[LOCAL_AW-1:0];
  assign use_local   = (global_addr == my_region);
  assign base        = use_local ? local_route : global_route;
  assign in_dim      = port_dim(in_port);
  assign out_dim     = port_dim(base.port);
  assign crosses     = (int'(base.port) < NPORTS) && dateline[base.port];

  always_comb begin
    decided.port = base.port;
    if (crosses)
      decided.vc = 1'b1;
    else if (out_dim != DIM_NONE && out_dim == in_dim)
      decided.vc = in_vc;
    else
      decided.vc = base.vc;
  end
endmodule

// File: rtl/flit_stage_reg.sv
module flit_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  logic         q_valid;
  logic [W-1:0] q_payload;

  assign in_ready    = !q_valid || out_ready;
  assign out_valid   = q_valid;
  assign out_payload = q_payload;

  always_ff @(posedge clk) begin
    if (!rst_n)        q_valid <= 1'b0;
    else if (in_ready) q_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     q_payload <= '0;
    else if (in_valid && in_ready)  q_payload <= in_payload;
  end
endmodule

// File: rtl/torus_route_stage.sv
module torus_route_stage
  import torus_route_pkg::*;
#(
  parameter int LOCAL_AW  = 12,
  parameter int GLOBAL_AW = 3,
  parameter int AGE_W     = 8,
  localparam int NODE_W   = LOCAL_AW + GLOBAL_AW,
  localparam int FLIT_W   = NODE_W + 1 + AGE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GLOBAL_AW-1:0] cfg_my_region,
  input  logic [PORT_W-1:0]    cfg_in_port,
  input  logic [NPORTS-1:0]    cfg_dateline,
  input  logic                 tbl_we,
  input  logic                 tbl_global,
  input  logic [LOCAL_AW-1:0]  tbl_addr,
  input  logic [PORT_W-1:0]    tbl_port,
  input  logic                 tbl_vc,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_head,
  input  logic                 in_tail,
  input  logic [FLIT_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_head,
  output logic                 out_tail,
  output logic [FLIT_W-1:0]    out_data,
  output logic [PORT_W-1:0]    out_port,
  output logic                 out_vc
);
  localparam int VC_BIT  = NODE_W;
  localparam int ROUTE_W = $bits(route_t);
  localparam int PAY_W   = 2 + ROUTE_W + FLIT_W;

  route_t                local_route, global_route, decided;
  route_t                pkt_route, flit_route, q_route, wr_route;
  logic [LOCAL_AW-1:0]   local_addr;
  logic [GLOBAL_AW-1:0]  global_addr;
  logic [FLIT_W-1:0]     data_mod;
  logic [PAY_W-1:0]      pay_in, pay_out;

  assign wr_route = '{port: tbl_port, vc: tbl_vc};

  route_table #(.AW(LOCAL_AW)) i_local_tbl (
    .clk   (clk),
    .we    (tbl_we && !tbl_global),
    .waddr (tbl_addr),
    .wdata (wr_route),
    .raddr (local_addr),
    .rdata (local_route)
  );

  route_table #(.AW(GLOBAL_AW)) i_global_tbl (
    .clk   (clk),
    .we    (tbl_we && tbl_global),
    .waddr (tbl_addr[GLOBAL_AW-1:0]),
    .wdata (wr_route),
    .raddr (global_addr),
    .rdata (global_route)
  );

  route_decide #(.LOCAL_AW(LOCAL_AW), .GLOBAL_AW(GLOBAL_AW)) i_decide (
    .dest         (in_data[NODE_W-1:0]),
    .in_vc        (in_data[VC_BIT]),
    .my_region    (cfg_my_region),
    .in_port      (cfg_in_port),
    .dateline     (cfg_dateline),
    .local_addr   (local_addr),
    .global_addr  (global_addr),
    .local_route  (local_route),
    .global_route (global_route),
    .decided      (decided)
  );

  // Route held for the body and tail flits of the current packet
  always_ff @(posedge clk) begin
    if (!rst_n)                                pkt_route <= '0;
    else if (in_valid && in_ready && in_head)  pkt_route <= decided;
  end

  assign flit_route = in_head ? decided : pkt_route;

  always_comb begin
    data_mod = in_data;
    if (in_head) data_mod[VC_BIT] = decided.vc;
  end

  assign pay_in = {in_head, in_tail, flit_route, data_mod};

  flit_stage_reg #(.W(PAY_W)) i_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (pay_in),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (pay_out)
  );

  assign {out_head, out_tail, q_route, out_data} = pay_out;
  assign out_port = q_route.port;
  assign out_vc   = q_route.vc;
endmodule

// File: rtl/route_stage_chk.sv
module route_stage_chk
  import torus_route_pkg::*;
#(
  parameter int LOCAL_AW  = 12,
  parameter int GLOBAL_AW = 3,
  parameter int AGE_W     = 8,
  localparam int NODE_W   = LOCAL_AW + GLOBAL_AW,
  localparam int FLIT_W   = NODE_W + 1 + AGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] cfg_dateline,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FLIT_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_head,
  input logic [FLIT_W-1:0] out_data,
  input logic [PORT_W-1:0] out_port,
  input logic              out_vc
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R7
  accept_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_port)
                                && $stable(out_vc) && $stable(out_head));

  // R4
  dateline_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && (int'(out_port) < NPORTS) && cfg_dateline[out_port] |-> out_vc);

  // R10
  age_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data[FLIT_W-1 -: AGE_W] == $past(in_data[FLIT_W-1 -: AGE_W]));

  // R10
  hdr_vc_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head |-> out_data[NODE_W] == out_vc);
endmodule

bind torus_route_stage route_stage_chk #(
  .LOCAL_AW (LOCAL_AW),
  .GLOBAL_AW(GLOBAL_AW),
  .AGE_W    (AGE_W)
) i_chk (.*);

// File: tb/test_torus_route_stage.sv
module test_torus_route_stage;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_my_region = 3'd3;
  logic [2:0]  cfg_in_port = 3'd1;
  logic [6:0]  cfg_dateline = 7'b0100100;
  logic        tbl_we = 1'b0, tbl_global = 1'b0, tbl_vc = 1'b0;
  logic [11:0] tbl_addr = '0;
  logic [2:0]  tbl_port = '0;
  logic        in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0, out_ready = 1'b1;
  logic [23:0] in_data = '0;
  logic        in_ready, out_valid, out_head, out_tail, out_vc;
  logic [23:0] out_data;
  logic [2:0]  out_port;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  torus_route_stage i_torus_route_stage (.*);

  // {dest, in_vc, age, exp_port, exp_vc}
  localparam logic [27:0] VEC [NVEC] = '{
    {15'h3005, 1'b0, 8'h11, 3'd5, 1'b1},
    {15'h3008, 1'b1, 8'h22, 3'd1, 1'b1},
    {15'h300F, 1'b0, 8'h33, 3'd1, 1'b0},
    {15'h3011, 1'b0, 8'h44, 3'd3, 1'b1},
    {15'h3004, 1'b1, 8'h55, 3'd4, 1'b0},
    {15'h3009, 1'b0, 8'h66, 3'd2, 1'b1},
    {15'h3000, 1'b1, 8'h77, 3'd0, 1'b0},
    {15'h5ABC, 1'b0, 8'h88, 3'd6, 1'b1},
    {15'h2123, 1'b1, 8'h99, 3'd3, 1'b0},
    {15'h1FFF, 1'b0, 8'hAA, 3'd2, 1'b1},
    {15'h3FFF, 1'b0, 8'hFF, 3'd0, 1'b1},
    {15'h7000, 1'b0, 8'h00, 3'd2, 1'b1},
    {15'h0456, 1'b1, 8'h5A, 3'd1, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic h, logic t, logic [23:0] d);
    in_valid = 1'b1; in_head = h; in_tail = t; in_data = d;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_head = 1'b0; in_tail = 1'b0;
  endtask

  task automatic chk_route(string req, logic [2:0] p, logic v, logic [23:0] d);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " port"}, 32'(out_port), 32'(p));
    chk({req, " vc"}, 32'(out_vc), 32'(v));
    chk({req, " data"}, 32'(out_data), 32'(d));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [27:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);

    // Load tables: node a -> port a%7, vc a[4]; region g -> port 1+g%6, vc g[0]
    tbl_we = 1'b1;
    tbl_global = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      tbl_addr = 12'(a); tbl_port = 3'(a % 7); tbl_vc = a[4];
      @(negedge clk);
    end
    tbl_global = 1'b1;
    for (int g = 0; g < 8; g++) begin
      tbl_addr = 12'(g); tbl_port = 3'(1 + g % 6); tbl_vc = g[0];
      @(negedge clk);
    end
    tbl_we = 1'b0;
    tbl_global = 1'b0;

    // Vector table: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      drive(1'b1, 1'b1, {v[11:4], v[12], v[27:13]});
      @(negedge clk);
      idle();
      chk_route("R2/R3/R4/R5/R6 vector", v[3:1], v[0], {v[11:4], v[0], v[27:13]});
      @(negedge clk);
    end

    // R7 R10: header, body, tail back to back
    drive(1'b1, 1'b0, {8'h44, 1'b0, 15'h3011});
    @(negedge clk);
    chk_route("R7 head", 3'd3, 1'b1, {8'h44, 1'b1, 15'h3011});
    chk("R7 in_ready streaming", 32'(in_ready), 32'd1);
    drive(1'b0, 1'b0, 24'h12B456);
    @(negedge clk);
    chk_route("R10 body follows header", 3'd3, 1'b1, 24'h12B456);
    drive(1'b0, 1'b1, 24'hABCDEF);
    @(negedge clk);
    chk_route("R10 tail follows header", 3'd3, 1'b1, 24'hABCDEF);
    chk("R10 tail flag", 32'(out_tail), 32'd1);
    idle();
    @(negedge clk);
    chk("R7 empty after drain", 32'(out_valid), 32'd0);

    // R8: back-pressure
    out_ready = 1'b0;
    drive(1'b1, 1'b1, {8'h44, 1'b0, 15'h3011});
    @(negedge clk);
    drive(1'b1, 1'b1, {8'h66, 1'b0, 15'h3009});
    for (int k = 0; k < 3; k++) begin
      chk("R8 in_ready low in stall", 32'(in_ready), 32'd0);
      chk_route("R8 hold in stall", 3'd3, 1'b1, {8'h44, 1'b1, 15'h3011});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    idle();
    chk_route("R8 next after release", 3'd2, 1'b1, {8'h66, 1'b1, 15'h3009});
    @(negedge clk);

    // R9: write during lookup returns old entry
    drive(1'b1, 1'b1, {8'h21, 1'b0, 15'h3005});
    tbl_we = 1'b1; tbl_global = 1'b0; tbl_addr = 12'd5; tbl_port = 3'd3; tbl_vc = 1'b0;
    @(negedge clk);
    tbl_we = 1'b0;
    chk_route("R9 old value on collision", 3'd5, 1'b1, {8'h21, 1'b1, 15'h3005});
    drive(1'b1, 1'b1, {8'h22, 1'b1, 15'h3005});
    @(negedge clk);
    idle();
    chk_route("R9 new value next cycle", 3'd3, 1'b0, {8'h22, 1'b0, 15'h3005});
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule